// File: doc/BRIEF.md
# General-Purpose I/O Port with Per-Pin Direction

This block is an eight-pin general-purpose port that sits on a simple register bus. It holds two registers: an output latch, which supplies the value each pin drives, and a direction register, which decides per pin whether the pad driver is enabled. Software writes either register through a one-bit address, a write strobe and an eight-bit write bus. Reads come back combinationally, in the same cycle.

A read of the output-latch address is assembled bit by bit. A pin set to output returns the latched bit. A pin set to input returns the pad level after a two-flop synchronizer. The two lowest pins double as interrupt request inputs, so they can never be driven. Their direction bits do not exist, and they are always readable as inputs.

While reset is held, the block raises pull-up requests on pins 7 and 3 and pull-down requests on pins 6 and 5. This keeps the pads at defined levels before software configures them.

Top module: `gpio_dirport`

## Requirements
- R1: While `rst_n` is low, and after its release, the output latch and the direction register read 0, `pin_oe` is 0, and a read returns 0 until pad levels propagate through the synchronizer.
- R2: A write with `bus_addr`=1 loads the direction register. From the next clock edge, `pin_oe[i]` is 1 exactly when direction bit i is 1 (1 = output, 0 = high-impedance input).
- R3: With `bus_addr`=0, read bit i equals the output-latch bit i whenever direction bit i is 1.
- R4: With `bus_addr`=0, read bit i equals `pin_in[i]` as sampled two rising clock edges earlier whenever direction bit i is 0.
- R5: Direction bits 1 and 0 always read 0 and ignore writes. `pin_oe[1:0]` is never 1.
- R6: Pins 1 and 0 are always returned at read bits 1 and 0 through the synchronizer path, whatever value was written to the direction register.
- R7: A write with `bus_addr`=0 loads all eight latch bits, including bits whose pins are inputs. `pin_out` shows the latch from the next edge, so a pin drives the stored value as soon as its direction turns to output.
- R8: `pull_up_en` is 8'b1000_1000 and `pull_dn_en` is 8'b0110_0000 while `rst_n` is low. Both are 0 while `rst_n` is high.
- R9: With `bus_addr`=1, the read data equals the direction register, with bits 1:0 as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 1 | Register select: 0 output latch, 1 direction |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| pin_in | input | 8 | Pad input levels, asynchronous |
| pin_out | output | 8 | Value driven to pads |
| pin_oe | output | 8 | Pad output enables |
| pull_up_en | output | 8 | Pull-up requests, active during reset |
| pull_dn_en | output | 8 | Pull-down requests, active during reset |

## Verification
The bench writes all ones to the direction register and checks that bits 1:0 stay clear on the read bus and on the enables. A design that implemented those bits would drive an interrupt input. It writes the latch while the pins are inputs and then flips the direction, expecting the stored value on the pads at once. A design that gated latch writes by direction would drive stale data. Pad toggles are read back one and two edges later, so a synchronizer with a missing or extra stage misreads. The pull outputs are checked both inside and outside reset, which catches swapped masks or pulls that stay on after reset.

// File: rtl/gpio_dirport_pkg.sv
package gpio_dirport_pkg;
   typedef enum logic {
      SEL_LATCH = 1'b0,
      SEL_DIR   = 1'b1
   } gpio_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);
   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= async_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
   import gpio_dirport_pkg::*;
#(
   parameter int               WIDTH      = 8,
   parameter logic [WIDTH-1:0] INPUT_ONLY = 8'h03
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  gpio_sel_e        wr_sel,
   input  logic [WIDTH-1:0] wr_data,
   output logic [WIDTH-1:0] latch_q,
   output logic [WIDTH-1:0] dir_q
);
   logic latch_wr, dir_wr;
   assign latch_wr = wr_en && (wr_sel == SEL_LATCH);
   assign dir_wr   = wr_en && (wr_sel == SEL_DIR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        latch_q <= '0;
      else if (latch_wr) latch_q <= wr_data;
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_dir
      if (INPUT_ONLY[i]) begin : g_fixed
         assign dir_q[i] = 1'b0;
      end else begin : g_flop
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      dir_q[i] <= 1'b0;
            else if (dir_wr) dir_q[i] <= wr_data[i];
         end
      end
   end
endmodule

// File: rtl/gpio_readmux.sv
module gpio_readmux
   import gpio_dirport_pkg::*;
#(
   parameter int               WIDTH      = 8,
   parameter logic [WIDTH-1:0] INPUT_ONLY = 8'h03
) (
   input  gpio_sel_e        rd_sel,
   input  logic [WIDTH-1:0] latch_q,
   input  logic [WIDTH-1:0] dir_q,
   input  logic [WIDTH-1:0] pad_sync,
   output logic [WIDTH-1:0] rd_data
);
   logic [WIDTH-1:0] port_view;

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      if (INPUT_ONLY[i]) begin : g_in
         assign port_view[i] = pad_sync[i];
      end else begin : g_bidir
         assign port_view[i] = dir_q[i] ? latch_q[i] : pad_sync[i];
      end
   end

   always_comb begin
      unique case (rd_sel)
         SEL_DIR: rd_data = dir_q;
         default: rd_data = port_view;
      endcase
   end
endmodule

// File: rtl/gpio_dirport.sv
module gpio_dirport
   import gpio_dirport_pkg::*;
#(
   parameter int               WIDTH       = 8,
   parameter int               SYNC_STAGES = 2,
   parameter logic [WIDTH-1:0] INPUT_ONLY  = 8'h03,
   parameter logic [WIDTH-1:0] PULLUP_SET  = 8'h88,
   parameter logic [WIDTH-1:0] PULLDN_SET  = 8'h60
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_addr,
   input  logic             bus_we,
   input  logic [WIDTH-1:0] bus_wdata,
   output logic [WIDTH-1:0] bus_rdata,
   input  logic [WIDTH-1:0] pin_in,
   output logic [WIDTH-1:0] pin_out,
   output logic [WIDTH-1:0] pin_oe,
   output logic [WIDTH-1:0] pull_up_en,
   output logic [WIDTH-1:0] pull_dn_en
);
   localparam logic [WIDTH-1:0] PULL_CLASH = PULLUP_SET & PULLDN_SET;

   if (WIDTH < 2) begin : g_bad_width
      $error("gpio_dirport: WIDTH must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("gpio_dirport: SYNC_STAGES must be at least 2");
   end
   if (PULL_CLASH != '0) begin : g_bad_pull
      $error("gpio_dirport: a pin cannot request both pulls");
   end

   gpio_sel_e        sel;
   logic [WIDTH-1:0] latch_q, dir_q, pad_sync;

   assign sel = gpio_sel_e'(bus_addr);

   gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (pin_in),
      .sync_out (pad_sync)
   );

   gpio_regbank #(.WIDTH(WIDTH), .INPUT_ONLY(INPUT_ONLY)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (bus_we),
      .wr_sel  (sel),
      .wr_data (bus_wdata),
      .latch_q (latch_q),
      .dir_q   (dir_q)
   );

   gpio_readmux #(.WIDTH(WIDTH), .INPUT_ONLY(INPUT_ONLY)) u_rmux (
      .rd_sel   (sel),
      .latch_q  (latch_q),
      .dir_q    (dir_q),
      .pad_sync (pad_sync),
      .rd_data  (bus_rdata)
   );

   assign pin_out    = latch_q;
   assign pin_oe     = dir_q;
   assign pull_up_en = rst_n ? '0 : PULLUP_SET;
   assign pull_dn_en = rst_n ? '0 : PULLDN_SET;
endmodule

// File: rtl/gpio_dirport_chk.sv
module gpio_dirport_chk #(
   parameter int               WIDTH       = 8,
   parameter int               SYNC_STAGES = 2,
   parameter logic [WIDTH-1:0] INPUT_ONLY  = 8'h03
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_addr,
   input logic             bus_we,
   input logic [WIDTH-1:0] bus_wdata,
   input logic [WIDTH-1:0] bus_rdata,
   input logic [WIDTH-1:0] pin_in,
   input logic [WIDTH-1:0] pin_out,
   input logic [WIDTH-1:0] pin_oe,
   input logic [WIDTH-1:0] pull_up_en,
   input logic [WIDTH-1:0] pull_dn_en
);
   logic [1:0] since_rst;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 since_rst <= '0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr) |=> (pin_oe == ($past(bus_wdata) & ~INPUT_ONLY)));

   p_latch_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_addr |-> ((bus_rdata & pin_oe) == (pin_out & pin_oe)));

   if (SYNC_STAGES == 2) begin : g_lat
      p_sync_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (!bus_addr && since_rst >= 2'd2) |->
            ((bus_rdata & ~pin_oe) == ($past(pin_in, 2) & ~pin_oe)));
   end

   p_input_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_oe & INPUT_ONLY) == '0);

   p_latch_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && !bus_addr) |=> (pin_out == $past(bus_wdata)));

   p_pull_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pull_up_en == '0) && (pull_dn_en == '0));

   p_dir_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
      bus_addr |-> (bus_rdata == pin_oe));
endmodule

bind gpio_dirport gpio_dirport_chk #(
   .WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES), .INPUT_ONLY(INPUT_ONLY)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
   .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
   .pin_out(pin_out), .pin_oe(pin_oe), .pull_up_en(pull_up_en),
   .pull_dn_en(pull_dn_en)
);

// File: tb/tb_gpio_dirport.sv
`timescale 1ns/1ps
module tb_gpio_dirport;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_addr = 1'b0, bus_we = 1'b0;
   logic [7:0] bus_wdata = '0, bus_rdata, pin_in = '0;
   logic [7:0] pin_out, pin_oe, pull_up_en, pull_dn_en;

   int n_vec = 0, n_bad = 0;
   bit done = 0;

   logic [7:0] m_latch = '0, m_dir = '0, m_s1 = '0, m_s2 = '0;

   always #4 clk = ~clk;

   gpio_dirport dut (.*);

   function automatic logic [7:0] exp_read(logic a);
      return a ? m_dir : ((m_latch & m_dir) | (m_s2 & ~m_dir));
   endfunction

   task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   // drive at negedge, check combinational outputs, then advance the model at posedge
   task automatic step(logic we, logic a, logic [7:0] wd, logic [7:0] pin);
      @(negedge clk);
      bus_we = we; bus_addr = a; bus_wdata = wd; pin_in = pin;
      #1;
      chk(a ? "R9 read dir" : "R3 R4 R6 read port", bus_rdata, exp_read(a));
      chk("R2 R5 oe", pin_oe, m_dir);
      chk("R7 pin_out", pin_out, m_latch);
      chk("R8 pulls off", pull_up_en | pull_dn_en, 8'h00);
      @(posedge clk);
      m_s2 = m_s1; m_s1 = pin;
      if (we && !a) m_latch = wd;
      if (we && a)  m_dir = wd & 8'hFC;
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      @(negedge clk);
      pin_in = 8'hA5;
      #1;
      chk("R8 pull-up in reset", pull_up_en, 8'h88);
      chk("R8 pull-down in reset", pull_dn_en, 8'h60);
      chk("R1 reset oe", pin_oe, 8'h00);
      chk("R1 reset read", bus_rdata, 8'h00);
      rst_n = 1'b1;
      pin_in = 8'h00;
      step(0, 0, 8'h00, 8'h00);
      step(0, 0, 8'h00, 8'h00);
      // R5: all-ones to direction, bits 1:0 must stay clear
      step(1, 1, 8'hFF, 8'h00);
      step(0, 1, 8'h00, 8'h00);
      chk("R5 oe low bits", pin_oe & 8'h03, 8'h00);
      // R6: low pins read as inputs even with every direction bit set
      step(0, 0, 8'h00, 8'h03);
      step(0, 0, 8'h00, 8'h03);
      step(0, 0, 8'h00, 8'h03);
      chk("R6 low pins readable", bus_rdata & 8'h03, 8'h03);
      // R7: latch written while inputs, then driven on direction change
      step(1, 1, 8'h00, 8'h00);
      step(1, 0, 8'h5A, 8'h00);
      step(1, 1, 8'hF0, 8'h00);
      step(0, 0, 8'h00, 8'h00);
      chk("R7 drives stored value", pin_out & pin_oe, 8'h50);
      // R4: latency of an input toggle
      step(1, 1, 8'h00, 8'h00);
      step(0, 0, 8'h00, 8'hFF);
      chk("R4 one edge old value", bus_rdata, 8'h00);
      step(0, 0, 8'h00, 8'hFF);
      step(0, 0, 8'h00, 8'hFF);
      chk("R4 two edges new value", bus_rdata, 8'hFF);
      for (int k = 0; k < 3000; k++)
         step(($urandom % 3) == 0, $urandom % 2, 8'($urandom), 8'($urandom));
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_vec++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule